// File: doc/BRIEF.md
# Vector Compare Mask Unit

This block compares the elements of a vector against a second vector or a scalar and records the outcome in a 64-bit mask register, one bit per element. The left operand of each comparison is either a scalar broadcast to every element or the element of a first vector, and the right operand is the element of a second vector. A 3-bit condition code selects the relation, and all comparisons are signed on 32-bit values.

An operation starts with a one-cycle `start` pulse that carries the condition, the operand source, the masked-mode settings, the element count and the scalar. The unit then walks the elements one per clock, presenting the current index on `elemIdx` so that an external register file can return both operands in the same cycle. Mask bits at or beyond the element count are never written. In masked mode a bit is rewritten only when its present value equals the match polarity; otherwise it keeps its value. A one-cycle `done` pulse marks the end of the operation.

Top module: `vcmp_mask_unit`

## Requirements
- R1: For each processed element i, mask bit i becomes 1 when the signed 32-bit relation (left op right) holds and 0 otherwise. The condition codes are 0 less than, 1 equal, 2 less or equal, 4 greater or equal, 5 not equal and 6 greater than.
- R2: When `useScalar` is 1, the left operand is the `scalarIn` value captured at start. When it is 0, the left operand is `elemA`. The right operand is always `elemB`.
- R3: Condition codes 3 and 7 are reserved. They leave the whole mask unchanged, and `done` follows one cycle after start.
- R4: Mask bits at index `vecLen` and above keep their value. A length of 0 changes nothing, and lengths above 64 are treated as 64.
- R5: When `maskEnable` is 1, a mask bit is rewritten only if its value before the operation equals `matchSel`. All other bits within the length keep their value.
- R6: One element is processed per clock, with `elemIdx` stepping from 0 to `vecLen`-1 on consecutive cycles. `done` is high for exactly one cycle and rises `vecLen`+1 cycles after the start edge.
- R7: `start` is ignored while `busy` is high, and an operation in progress keeps its captured settings.
- R8: After reset the mask is all zeros and both `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when the unit is idle |
| cond | input | 3 | Relation code, captured at start |
| useScalar | input | 1 | Left operand source: 1 scalar, 0 vector A |
| maskEnable | input | 1 | Enables masked (selective) update |
| matchSel | input | 1 | Value that a prior mask bit must have to be rewritten in masked mode |
| vecLen | input | 7 | Number of elements to process (0 to 64) |
| scalarIn | input | 32 | Scalar left operand, captured at start |
| elemA | input | 32 | Low 32 bits of vector A element at `elemIdx` |
| elemB | input | 32 | Low 32 bits of vector B element at `elemIdx` |
| elemIdx | output | 6 | Index of the element being processed |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mask | output | 64 | Mask register contents |

## Verification
The start pulse is sampled at one rising edge. Element i is requested through `elemIdx` in the cycle after edge i+1 and written at the following edge, and `done` is high in the cycle after edge `vecLen`+1, or after edge 1 for a reserved code or a zero length. The bench drives and samples on falling edges. It counts cycles from the start edge to `done`, checks `elemIdx` on each of those cycles, and compares the mask against its model only once `done` is seen. It then confirms that `done` has dropped one cycle later.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } ctrl_state_t;

  typedef struct packed {
    logic capture;
    logic writeBit;
  } dp_strobe_t;

  function automatic logic isReserved(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1),
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       cond,
  input  logic [LEN_W-1:0] vecLen,
  output dp_strobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  ctrl_state_t      state;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] effLen;
  logic             lastElem;

  assign effLen   = (vecLen > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vecLen;
  assign lastElem = (LEN_W'(idx) + LEN_W'(1)) == lenReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      lenReg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lenReg <= effLen;
            idx    <= '0;
            if (isReserved(cond) || effLen == '0) state <= ST_FINISH;
            else                                  state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastElem) state <= ST_FINISH;
          else          idx   <= idx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.capture  = (state == ST_IDLE) && start;
  assign strobe.writeBit = (state == ST_RUN);
  assign busy            = (state != ST_IDLE);
  assign done            = (state == ST_FINISH);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: no element at or past the captured length is ever written
  a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.writeBit |-> (LEN_W'(idx) < lenReg));

  // R3: a reserved code skips straight to completion
  a_r3_reserved_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && isReserved(cond)) |=> (state == ST_FINISH));

  // R7: captured length holds while the unit is busy
  a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lenReg));

endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int CMP_W    = 32,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dp_strobe_t          strobe,
  input  logic [IDX_W-1:0]    idx,
  input  logic [2:0]          cond,
  input  logic                useScalar,
  input  logic                maskEnable,
  input  logic                matchSel,
  input  logic [CMP_W-1:0]    scalarIn,
  input  logic [CMP_W-1:0]    elemA,
  input  logic [CMP_W-1:0]    elemB,
  output logic [NUM_ELEM-1:0] maskOut
);

  logic [2:0]          condReg;
  logic                useScReg;
  logic                mEnReg;
  logic                mSelReg;
  logic [CMP_W-1:0]    scalarReg;
  logic [NUM_ELEM-1:0] maskReg;

  logic signed [CMP_W-1:0] lhs;
  logic signed [CMP_W-1:0] rhs;
  logic isLess;
  logic isEqual;
  logic baseRel;
  logic relHolds;
  logic allowWrite;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      condReg   <= '0;
      useScReg  <= 1'b0;
      mEnReg    <= 1'b0;
      mSelReg   <= 1'b0;
      scalarReg <= '0;
    end else if (strobe.capture) begin
      condReg   <= cond;
      useScReg  <= useScalar;
      mEnReg    <= maskEnable;
      mSelReg   <= matchSel;
      scalarReg <= scalarIn;
    end
  end

  assign lhs     = useScReg ? scalarReg : elemA;
  assign rhs     = elemB;
  assign isLess  = lhs < rhs;
  assign isEqual = lhs == rhs;

  // bit 2 of the code inverts the base relation selected by bits 1:0
  always_comb begin
    unique case (condReg[1:0])
      2'd0:    baseRel = isLess;
      2'd1:    baseRel = isEqual;
      2'd2:    baseRel = isLess | isEqual;
      default: baseRel = 1'b0;
    endcase
  end

  assign relHolds   = baseRel ^ condReg[2];
  assign allowWrite = !mEnReg || (maskReg[idx] == mSelReg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskReg <= '0;
    end else if (strobe.writeBit && allowWrite) begin
      maskReg[idx] <= relHolds;
    end
  end

  assign maskOut = maskReg;

  // R5: masked mode keeps a bit whose value differs from the polarity
  a_r5_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.writeBit && mEnReg && (maskReg[idx] != mSelReg)) |=> $stable(maskReg));

  // R4: the mask moves only on element write cycles
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.writeBit |=> $stable(maskReg));

  // R1: at most one mask bit changes per processed element
  a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.writeBit |=> ($countones(maskReg ^ $past(maskReg)) <= 1));

endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
  import vcmp_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int CMP_W    = 32,
  localparam int LEN_W   = $clog2(NUM_ELEM + 1),
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          cond,
  input  logic                useScalar,
  input  logic                maskEnable,
  input  logic                matchSel,
  input  logic [LEN_W-1:0]    vecLen,
  input  logic [CMP_W-1:0]    scalarIn,
  input  logic [CMP_W-1:0]    elemA,
  input  logic [CMP_W-1:0]    elemB,
  output logic [IDX_W-1:0]    elemIdx,
  output logic                busy,
  output logic                done,
  output logic [NUM_ELEM-1:0] mask
);

  dp_strobe_t strobe;

  vcmp_ctrl #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cond   (cond),
    .vecLen (vecLen),
    .strobe (strobe),
    .idx    (elemIdx),
    .busy   (busy),
    .done   (done)
  );

  vcmp_datapath #(.NUM_ELEM(NUM_ELEM), .CMP_W(CMP_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .idx        (elemIdx),
    .cond       (cond),
    .useScalar  (useScalar),
    .maskEnable (maskEnable),
    .matchSel   (matchSel),
    .scalarIn   (scalarIn),
    .elemA      (elemA),
    .elemB      (elemB),
    .maskOut    (mask)
  );

endmodule

// File: tb/vcmp_mask_unit_test.sv
module vcmp_mask_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cond = '0;
  logic        useScalar = 1'b0;
  logic        maskEnable = 1'b0;
  logic        matchSel = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [31:0] scalarIn = '0;
  logic [31:0] elemA;
  logic [31:0] elemB;
  logic [5:0]  elemIdx;
  logic        busy;
  logic        done;
  logic [63:0] mask;

  logic [31:0] vecA [N];
  logic [31:0] vecB [N];
  logic [63:0] expMask = '0;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign elemA = vecA[elemIdx];
  assign elemB = vecB[elemIdx];

  vcmp_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
    .useScalar(useScalar), .maskEnable(maskEnable), .matchSel(matchSel),
    .vecLen(vecLen), .scalarIn(scalarIn), .elemA(elemA), .elemB(elemB),
    .elemIdx(elemIdx), .busy(busy), .done(done), .mask(mask)
  );

  function automatic logic relOf(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] sa = a;
    logic signed [31:0] sb = b;
    case (c)
      3'd0: return sa < sb;
      3'd1: return sa == sb;
      3'd2: return sa <= sb;
      3'd4: return sa >= sb;
      3'd5: return sa != sb;
      3'd6: return sa > sb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [2:0] c, input logic us,
                       input logic me, input logic ms, input int len,
                       input logic [31:0] sc, input logic inject);
    int cycles;
    int effLen;
    logic idxOk;
    logic reserved;
    effLen   = (len > N) ? N : len;
    reserved = (c[1:0] == 2'b11);
    for (int i = 0; i < effLen; i++) begin
      if (!reserved && (!me || expMask[i] == ms))
        expMask[i] = relOf(c, us ? sc : vecA[i], vecB[i]);
    end
    @(negedge clk);
    cond = c; useScalar = us; maskEnable = me; matchSel = ms;
    vecLen = 7'(len); scalarIn = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    idxOk = 1'b1;
    while (!done && cycles < 300) begin
      if (!reserved && cycles <= effLen && elemIdx != 6'(cycles - 1)) idxOk = 1'b0;
      if (inject && cycles == 2) begin
        start = 1'b1; cond = ~c; useScalar = ~us; maskEnable = ~me;
        matchSel = ~ms; vecLen = 7'd64; scalarIn = ~sc;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check({tag, " R6 latency"}, 64'(cycles), reserved ? 64'd1 : 64'(effLen + 1));
    check({tag, " R6 index walk"}, 64'(idxOk), 64'd1);
    check({tag, " mask"}, mask, expMask);
    @(negedge clk);
    check({tag, " R6 done pulse"}, {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < N; i++) begin vecA[i] = '0; vecB[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 reset", {mask[61:0], done, busy}, 64'd0);

    // R1 each relation on a crafted vector pair: less, equal, greater, signed extremes
    for (int i = 0; i < N; i++) begin
      case (i % 4)
        0: begin vecA[i] = 32'hFFFF_FFFF; vecB[i] = 32'd1; end
        1: begin vecA[i] = 32'd7; vecB[i] = 32'd7; end
        2: begin vecA[i] = 32'd5; vecB[i] = 32'h8000_0000; end
        default: begin vecA[i] = 32'h7FFF_FFFF; vecB[i] = 32'h8000_0000; end
      endcase
    end
    runOp("R1 lt", 3'd0, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    runOp("R1 eq", 3'd1, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    runOp("R1 le", 3'd2, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    runOp("R1 ge", 3'd4, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    runOp("R1 ne", 3'd5, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    runOp("R1 gt", 3'd6, 1'b0, 1'b0, 1'b0, 16, '0, 1'b0);
    // R2 scalar broadcast
    runOp("R2 scalar", 3'd1, 1'b1, 1'b0, 1'b0, 64, 32'd7, 1'b0);
    runOp("R2 scalar neg", 3'd0, 1'b1, 1'b0, 1'b0, 40, 32'h8000_0001, 1'b0);
    // R3 reserved codes
    runOp("R3 code3", 3'd3, 1'b0, 1'b0, 1'b0, 64, '0, 1'b0);
    runOp("R3 code7", 3'd7, 1'b1, 1'b0, 1'b0, 64, 32'd7, 1'b0);
    // R4 length boundaries
    runOp("R4 len0", 3'd5, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0);
    runOp("R4 len1", 3'd2, 1'b0, 1'b0, 1'b0, 1, '0, 1'b0);
    runOp("R4 len100", 3'd4, 1'b0, 1'b0, 1'b0, 100, '0, 1'b0);
    // R5 masked mode both polarities
    runOp("R5 match1", 3'd0, 1'b0, 1'b1, 1'b1, 64, '0, 1'b0);
    runOp("R5 match0", 3'd6, 1'b0, 1'b1, 1'b0, 64, '0, 1'b0);
    // R7 start during busy
    runOp("R7 busy start", 3'd1, 1'b1, 1'b0, 1'b0, 30, 32'd7, 1'b1);

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [2:0] c;
      for (int i = 0; i < N; i++) begin
        vecA[i] = ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom;
        vecB[i] = ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom;
      end
      c = 3'($urandom);
      runOp("R1 R2 R5 random", c, 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom % 70), 32'($urandom % 4), 1'($urandom % 8 == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule